// File: doc/BRIEF.md
# SPI Flash User-Mode Access Engine

This block sits between a memory-mapped bus and a byte-exchange port of an SPI shifter. Software selects a flash device by clearing that device's chip-select-inactive bit in its control register. It then reads or writes 1 to 4 bytes through a flash window. Every byte of such an access becomes one full-duplex SPI byte exchange. Exchanges run one at a time, and the least significant byte goes first.

Each chip select has its own control register. The control register holds a two-bit access-mode field and the chip-select-inactive bit, and that bit drives the matching chip-select pin directly. Window traffic moves only when the addressed chip select is in user mode (mode field = 3). Window writes also need that chip select's write-enable bit in the configuration register. A window access is held in a wait state until all of its exchanges are done, and `winReady` pulses for one cycle to end it.

The register port is a simple single-cycle port. Writes take effect at the clock edge. Reads are combinational from `regAddr`. The number of implemented chip selects is set by `NUM_CS` (1 to 5).

Top module: `flash_user_port`

## Requirements
- R1: After reset the configuration register (byte offset 0x00) and the CE control register (0x04) read 0. The interrupt register (0x08) reads 0x0000_0800. Every implemented per-CS control register (0x10 + 4·n) reads 0x0000_0004, and every `csN` output is 1.
- R2: Bit 2 of the control register of chip select n drives `csN[n]` directly, from the clock edge at which that register is written.
- R3: Control registers for n ≥ `NUM_CS` read 0 and ignore writes. The interrupt register ignores writes. Any offset not listed in R1 reads 0.
- R4: A window read to a chip select whose mode field (bits [1:0]) equals 3 performs exactly `winSize`+1 exchanges and sends 0x00 in each. Received byte i appears at `winRdata[8i+7:8i]`, and the unused upper bytes are 0.
- R5: A window write in user mode to a chip select whose write enable is set performs exactly `winSize`+1 exchanges, sending `winWdata[7:0]` first and then each higher byte in order.
- R6: The write enable for chip select n is configuration bit 16+n. A window write to a chip select whose enable bit is clear completes with no exchange.
- R7: A window read to a chip select whose mode is not 3 (including an unimplemented chip select) returns 0xFFFF_FFFF with no exchange. A window write in such a mode completes with no exchange.
- R8: At most one exchange is outstanding at any time. `xchgStart` never pulses while an exchange awaits `xchgDone`, and `winReady` is never given while an exchange is outstanding.
- R9: The configuration and CE control registers read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| winReq | input | 1 | Window access request, held until `winReady` |
| winWrite | input | 1 | 1 = window write, 0 = window read |
| winCs | input | 3 | Chip select addressed by the window access |
| winSize | input | 2 | Access size in bytes minus one |
| winWdata | input | 32 | Window write data |
| winRdata | output | 32 | Window read data, valid with `winReady` |
| winReady | output | 1 | One-cycle completion of a window access |
| xchgStart | output | 1 | One-cycle start of an SPI byte exchange |
| xchgTx | output | 8 | Byte to send, valid with `xchgStart` |
| xchgRx | input | 8 | Byte received, valid with `xchgDone` |
| xchgDone | input | 1 | Exchange finished |
| csN | output | NUM_CS | Chip-select outputs, 1 = deselected |

## Verification
A byte counter or shift register that goes wrong inside this block shows at the exchange port within the same access. It appears as an extra or a missing `xchgStart`, or as a misordered `xchgTx` byte. A wrong receive lane shows in `winRdata` at the `winReady` pulse. A wrong mode or enable decode makes exchanges happen, or fail to happen, on the very first request. Because the chip-select pins follow the register bits directly, a corrupted control register shows on `csN` one edge after the write.

// File: rtl/flash_user_pkg.sv
package flash_user_pkg;
  localparam int MAX_CS  = 5;
  localparam int SEL_W   = 3;
  localparam int SLOTS   = 1 << SEL_W;
  localparam int WEN_LSB = 16;
  localparam int CSOFF_BIT = 2;
  localparam logic [1:0] MODE_USER = 2'd3;
  localparam logic [31:0] INTR_RESET = 32'h0000_0800;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} fsm_e;

  typedef struct packed {
    logic load;
    logic capture;
    logic fillOnes;
  } strobes_t;
endpackage

// File: rtl/flash_user_regs.sv
module flash_user_regs
  import flash_user_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrite,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [SEL_W-1:0] winCs,
  output logic             selUser,
  output logic             selWen,
  output logic [NUM_CS-1:0] csN
);
  logic [31:0] cfgReg, ceReg;
  logic [31:0] ctrlArr [SLOTS];
  logic        isCtrlAddr;
  logic [SEL_W-1:0] ctrlIdx;

  assign isCtrlAddr = (regAddr >= 8'h10) && (regAddr <= 8'h20) && (regAddr[1:0] == 2'b00);
  assign ctrlIdx    = SEL_W'(regAddr[5:2] - 4'd4);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
      ceReg  <= '0;
    end else if (regWrite) begin
      if (regAddr == 8'h00) cfgReg <= regWdata;
      if (regAddr == 8'h04) ceReg  <= regWdata;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_CS) begin : g_impl
      logic [31:0] ctrlQ;
      always_ff @(posedge clk) begin
        if (!rstN) ctrlQ <= 32'h1 << CSOFF_BIT;
        else if (regWrite && isCtrlAddr && ctrlIdx == SEL_W'(i)) ctrlQ <= regWdata;
      end
      assign ctrlArr[i] = ctrlQ;
      assign csN[i]     = ctrlQ[CSOFF_BIT];

      // R2
      cs_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
        (regWrite && regAddr == 8'(16 + 4*i)) |=> (csN[i] == $past(regWdata[CSOFF_BIT])));
    end else begin : g_none
      assign ctrlArr[i] = '0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == 8'h00)      regRdata = cfgReg;
    else if (regAddr == 8'h04) regRdata = ceReg;
    else if (regAddr == 8'h08) regRdata = INTR_RESET;
    else if (isCtrlAddr)       regRdata = ctrlArr[ctrlIdx];
  end

  assign selUser = (ctrlArr[winCs][1:0] == MODE_USER);
  assign selWen  = cfgReg[5'(WEN_LSB) + 5'(winCs)];
endmodule

// File: rtl/flash_user_ctrl.sv
module flash_user_ctrl
  import flash_user_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       winReq,
  input  logic       winWrite,
  input  logic [1:0] winSize,
  input  logic       selUser,
  input  logic       selWen,
  input  logic       xchgDone,
  output logic       xchgStart,
  output logic       winReady,
  output logic [1:0] byteIdx,
  output strobes_t   strobe
);
  fsm_e       state, nextState;
  logic [1:0] sizeQ;
  logic       pendQ;
  logic       allowed;

  assign allowed = selUser && (!winWrite || selWen);

  always_comb begin
    nextState = state;
    strobe    = '0;
    xchgStart = 1'b0;
    winReady  = 1'b0;
    unique case (state)
      ST_IDLE: if (winReq) begin
        if (allowed) begin
          strobe.load = 1'b1;
          nextState   = ST_ISSUE;
        end else begin
          strobe.fillOnes = !winWrite;
          nextState       = ST_RESP;
        end
      end
      ST_ISSUE: begin
        xchgStart = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: if (xchgDone) begin
        strobe.capture = 1'b1;
        nextState      = (byteIdx == sizeQ) ? ST_RESP : ST_ISSUE;
      end
      ST_RESP: begin
        winReady  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sizeQ   <= '0;
      byteIdx <= '0;
      pendQ   <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.load) begin
        sizeQ   <= winSize;
        byteIdx <= '0;
      end else if (strobe.capture) begin
        byteIdx <= byteIdx + 2'd1;
      end
      if (xchgStart)     pendQ <= 1'b1;
      else if (xchgDone) pendQ <= 1'b0;
    end
  end

  // R8
  one_xchg_chk: assert property (@(posedge clk) disable iff (!rstN)
    xchgStart |-> !pendQ);
  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    winReady |-> !pendQ);
  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (byteIdx <= sizeQ));
  // R6
  denied_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && winReq && winWrite && !selWen) |=> !xchgStart);
  // R7
  nonuser_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && winReq && !selUser) |=> winReady);
endmodule

// File: rtl/flash_user_datapath.sv
module flash_user_datapath
  import flash_user_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobes_t    strobe,
  input  logic [1:0]  byteIdx,
  input  logic        winWrite,
  input  logic [31:0] winWdata,
  input  logic [7:0]  xchgRx,
  output logic [7:0]  xchgTx,
  output logic [31:0] winRdata,
  output logic        writeQ
);
  logic [31:0] txShift, rxAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxAcc   <= '0;
      writeQ  <= 1'b0;
    end else if (strobe.load) begin
      txShift <= winWrite ? winWdata : '0;
      rxAcc   <= '0;
      writeQ  <= winWrite;
    end else if (strobe.capture) begin
      txShift <= txShift >> 8;
      rxAcc[{byteIdx, 3'b000} +: 8] <= xchgRx;
    end else if (strobe.fillOnes) begin
      rxAcc <= '1;
    end
  end

  assign xchgTx   = txShift[7:0];
  assign winRdata = rxAcc;
endmodule

// File: rtl/flash_user_port.sv
module flash_user_port
  import flash_user_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              winReq,
  input  logic              winWrite,
  input  logic [2:0]        winCs,
  input  logic [1:0]        winSize,
  input  logic [31:0]       winWdata,
  output logic [31:0]       winRdata,
  output logic              winReady,
  output logic              xchgStart,
  output logic [7:0]        xchgTx,
  input  logic [7:0]        xchgRx,
  input  logic              xchgDone,
  output logic [NUM_CS-1:0] csN
);
  logic     selUser, selWen, writeQ;
  logic [1:0] byteIdx;
  strobes_t strobe;

  flash_user_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .winCs(winCs),
    .selUser(selUser), .selWen(selWen), .csN(csN));

  flash_user_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .winReq(winReq), .winWrite(winWrite),
    .winSize(winSize), .selUser(selUser), .selWen(selWen),
    .xchgDone(xchgDone), .xchgStart(xchgStart), .winReady(winReady),
    .byteIdx(byteIdx), .strobe(strobe));

  flash_user_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIdx(byteIdx),
    .winWrite(winWrite), .winWdata(winWdata), .xchgRx(xchgRx),
    .xchgTx(xchgTx), .winRdata(winRdata), .writeQ(writeQ));

  // R4
  read_zero_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xchgStart && !writeQ) |-> (xchgTx == 8'h00));
endmodule

// File: tb/test_flash_user_port.sv
module test_flash_user_port;
  localparam int NCS = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrite = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic winReq = 1'b0, winWrite = 1'b0;
  logic [2:0] winCs = '0;
  logic [1:0] winSize = '0;
  logic [31:0] winWdata = '0, winRdata;
  logic winReady, xchgStart, xchgDone = 1'b0;
  logic [7:0] xchgTx, xchgRx = '0;
  logic [NCS-1:0] csN;

  int tests = 0, fails = 0;
  int xchgCount = 0;
  logic [7:0] txLog [8];

  always #2 clk = ~clk;

  flash_user_port #(.NUM_CS(NCS)) i_flash_user_port (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .winReq(winReq),
    .winWrite(winWrite), .winCs(winCs), .winSize(winSize),
    .winWdata(winWdata), .winRdata(winRdata), .winReady(winReady),
    .xchgStart(xchgStart), .xchgTx(xchgTx), .xchgRx(xchgRx),
    .xchgDone(xchgDone), .csN(csN));

  // SPI shifter model: answers 0x50 + exchange number after two cycles
  initial begin
    forever begin
      if (xchgStart === 1'b1) begin
        if (xchgCount < 8) txLog[xchgCount] = xchgTx;
        xchgRx = 8'h50 + 8'(xchgCount);
        xchgCount++;
        repeat (2) @(negedge clk);
        xchgDone = 1'b1;
        @(negedge clk);
        xchgDone = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic win(input bit wr, input logic [2:0] cs, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd);
    int guard = 0;
    xchgCount = 0;
    @(negedge clk);
    winReq = 1'b1; winWrite = wr; winCs = cs; winSize = sz; winWdata = wd;
    do begin
      @(negedge clk);
      guard++;
    end while (winReady !== 1'b1 && guard < 200);
    rd = winRdata;
    check(guard < 200, "R8 ready timeout", 32'(guard), 32'd0);
    winReq = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    regRd(8'h00, d); check(d == 0, "R1 cfg", d, 0);
    regRd(8'h04, d); check(d == 0, "R1 ce", d, 0);
    regRd(8'h08, d); check(d == 32'h800, "R1 intr", d, 32'h800);
    for (int i = 0; i < NCS; i++) begin
      regRd(8'(16 + 4*i), d); check(d == 32'h4, "R1 ctrl", d, 32'h4);
    end
    check(csN == '1, "R1 csN", 32'(csN), 32'hF);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    regWr(8'h00, 32'h000F_00A5); regRd(8'h00, d); check(d == 32'h000F_00A5, "R9 cfg", d, 32'h000F_00A5);
    regWr(8'h04, 32'hC000_001F); regRd(8'h04, d); check(d == 32'hC000_001F, "R9 ce", d, 32'hC000_001F);
    regWr(8'h20, 32'hFFFF_FFFF); regRd(8'h20, d); check(d == 0, "R3 unimpl ctrl", d, 0);
    regWr(8'h08, 32'h0); regRd(8'h08, d); check(d == 32'h800, "R3 intr ro", d, 32'h800);
    regRd(8'h40, d); check(d == 0, "R3 unmapped", d, 0);
  endtask

  task automatic t_cs();
    logic [31:0] d;
    regWr(8'h14, 32'h3);
    check(csN == 4'b1101, "R2 cs1 low", 32'(csN), 32'hD);
    regRd(8'h14, d); check(d == 32'h3, "R2 readback", d, 3);
    regWr(8'h18, 32'h6);
    check(csN == 4'b1101, "R2 cs2 high", 32'(csN), 32'hD);
  endtask

  task automatic t_user_read();
    logic [31:0] d;
    win(1'b0, 3'd1, 2'd3, 32'h0, d);
    check(d == 32'h5352_5150, "R4 4-byte data", d, 32'h5352_5150);
    check(xchgCount == 4, "R4 4-byte count", 32'(xchgCount), 4);
    check(txLog[0] == 0 && txLog[3] == 0, "R4 tx zero", {txLog[0], txLog[3]}, 0);
    win(1'b0, 3'd1, 2'd1, 32'h0, d);
    check(d == 32'h0000_5150, "R4 2-byte data", d, 32'h5150);
    check(xchgCount == 2, "R4 2-byte count", 32'(xchgCount), 2);
  endtask

  task automatic t_user_write();
    logic [31:0] d;
    win(1'b1, 3'd1, 2'd2, 32'hDDCC_BBAA, d);
    check(xchgCount == 3, "R5 count", 32'(xchgCount), 3);
    check({txLog[0], txLog[1], txLog[2]} == 24'hAABBCC, "R5 order",
          32'({txLog[0], txLog[1], txLog[2]}), 32'hAABBCC);
    win(1'b1, 3'd1, 2'd0, 32'h1234_5678, d);
    check(xchgCount == 1 && txLog[0] == 8'h78, "R5 single", 32'(txLog[0]), 32'h78);
  endtask

  task automatic t_wen_block();
    logic [31:0] d;
    regWr(8'h00, 32'h0001_0000);
    win(1'b1, 3'd1, 2'd3, 32'hFFFF_FFFF, d);
    check(xchgCount == 0, "R6 dropped", 32'(xchgCount), 0);
    regWr(8'h00, 32'h000F_0000);
  endtask

  task automatic t_nonuser();
    logic [31:0] d;
    regWr(8'h10, 32'h0);
    win(1'b0, 3'd0, 2'd3, 32'h0, d);
    check(d == 32'hFFFF_FFFF && xchgCount == 0, "R7 read mode0", d, 32'hFFFF_FFFF);
    regWr(8'h18, 32'h2);
    win(1'b1, 3'd2, 2'd1, 32'h55AA, d);
    check(xchgCount == 0, "R7 write mode2", 32'(xchgCount), 0);
    win(1'b0, 3'd4, 2'd0, 32'h0, d);
    check(d == 32'hFFFF_FFFF && xchgCount == 0, "R7 unimpl cs", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_regs();
        t_cs();
        t_user_read();
        t_user_write();
        t_wen_block();
        t_nonuser();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule